// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Line Ownership

This block drives 32 general-purpose pins from two independent register banks, called bank A and bank B. Each bank holds its own output data, output enable, interrupt polarity, interrupt mask and interrupt flag registers. Each bank also has two read-only views of the synchronized pin levels. An ownership register in bank B holds one bit per line. That bit decides which bank drives the line's pad output and output enable, and which bank's interrupt logic watches the line. Two software agents can therefore share one set of pins. Each agent uses its own bank and never sees the other's state.

Each bank has a simple word-indexed register port: select, write strobe, 4-bit index, write data and combinational read data. Pad inputs pass through a two-flop synchronizer before any register or interrupt logic sees them. Interrupts are level sensitive. On every clock, a flag bit is set while an owned line's synchronized level matches the programmed polarity. A bank's interrupt output is high while any of its flags is both set and unmasked.

Top module: `gpio_dual_bank`

## Requirements
- R1: After reset, pad_out and pad_oe are all zero, both interrupt outputs are low, and the ownership register reads 0xFFFFFFFF.
- R2: For each line n, pad_out[n] and pad_oe[n] follow bank A's output and direction bit n when ownership bit n is 1, and bank B's bits when it is 0.
- R3: Writes to the output or direction bits of the bank that does not own a line are stored and read back, but they leave pad_out and pad_oe unchanged.
- R4: A pad input change becomes visible in the pin view (index 5) and the mirror view (index 6) of both banks after the second rising clock edge, not after the first. This holds for every line, whatever its owner.
- R5: A bank's flag bit n sets on the clock edge that follows the synchronized level of line n matching polarity bit n (1 = active high, 0 = active low). The line must be owned by that bank, and the mask bit has no effect on this.
- R6: A bank never sets the flag of a line it does not own.
- R7: Writing to the flag register (index 4) clears every bit written as 1 whose condition is no longer active. Bits written as 0 are left unchanged.
- R8: A bank's interrupt output is high exactly while some line has both its flag bit and its mask bit set.
- R9: A set flag stays set after its level condition goes away, until it is cleared by a write.
- R10: Register indices are 0 output, 1 direction, 2 polarity, 3 mask, 4 flag, 5 pin, 6 pin mirror. Bank B adds 7 ownership and 8 auxiliary enable. Every other index, and indices 7 and 8 on bank A, reads as zero.
- R11: The auxiliary enable register (bank B index 8) is stored and read back, and it has no effect on the pads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_sel | input | 1 | Bank A access select |
| a_wr | input | 1 | Bank A write strobe |
| a_idx | input | 4 | Bank A register index |
| a_wdata | input | 32 | Bank A write data |
| a_rdata | output | 32 | Bank A read data |
| b_sel | input | 1 | Bank B access select |
| b_wr | input | 1 | Bank B write strobe |
| b_idx | input | 4 | Bank B register index |
| b_wdata | input | 32 | Bank B write data |
| b_rdata | output | 32 | Bank B read data |
| pad_in | input | 32 | Raw pad levels |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables |
| a_irq | output | 1 | Bank A interrupt |
| b_irq | output | 1 | Bank B interrupt |

## Verification
The checker watches several rules on every cycle. Flags are never set on lines a bank does not own. A flag write clears the written bits unless their condition is still active. Flags only fall through a flag write. Pad drive changes only after a register write, and a bank with an all-zero mask never raises its interrupt. Other behaviour needs the bench's directed scenarios: the exact two-edge synchronizer latency, hand-over of a line when ownership changes, the polarity choice per line, and the zero reads of unmapped indices.

// File: rtl/gpio_dual_bank_pkg.sv
package gpio_dual_bank_pkg;
  localparam int unsigned LINES = 32;
  localparam int unsigned IDX_W = 4;

  typedef enum logic [IDX_W-1:0] {
    IDX_DOUT   = 4'd0,
    IDX_DIR    = 4'd1,
    IDX_POL    = 4'd2,
    IDX_MASK   = 4'd3,
    IDX_FLAG   = 4'd4,
    IDX_PIN    = 4'd5,
    IDX_PINMIR = 4'd6,
    IDX_OWNER  = 4'd7,
    IDX_AUX    = 4'd8
  } reg_idx_e;

  // Lines whose synchronized level equals their polarity and are owned
  function automatic logic [LINES-1:0] level_hits(input logic [LINES-1:0] lvl,
                                                  input logic [LINES-1:0] pol,
                                                  input logic [LINES-1:0] owned);
    return owned & ~(lvl ^ pol);
  endfunction

  // Next flag state: set beats clear when both hit the same line
  function automatic logic [LINES-1:0] flag_next(input logic [LINES-1:0] cur,
                                                 input logic [LINES-1:0] clr,
                                                 input logic [LINES-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic pending(input logic [LINES-1:0] flag,
                                   input logic [LINES-1:0] mask);
    return |(flag & mask);
  endfunction
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_dual_bank_pkg::*;
#(
  parameter int unsigned W         = LINES,
  parameter bit          HAS_OWNER = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr,
  input  logic [IDX_W-1:0] idx,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata,
  input  logic [W-1:0]     lvl,
  input  logic [W-1:0]     owned,
  output logic [W-1:0]     dout_q,
  output logic [W-1:0]     dir_q,
  output logic [W-1:0]     flag_q,
  output logic [W-1:0]     mask_q,
  output logic [W-1:0]     set_v,
  output logic [W-1:0]     own_q,
  output logic             irq
);
  logic [W-1:0] pol_q;
  logic [W-1:0] aux_q;
  logic [W-1:0] clr_v;
  logic         wen;

  assign wen   = sel && wr;
  assign set_v = level_hits(lvl, pol_q, owned);
  assign clr_v = (wen && idx == IDX_FLAG) ? wdata : '0;
  assign irq   = pending(flag_q, mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
      pol_q  <= '0;
      mask_q <= '0;
      flag_q <= '0;
    end else begin
      flag_q <= flag_next(flag_q, clr_v, set_v);
      if (wen) begin
        case (idx)
          IDX_DOUT: dout_q <= wdata;
          IDX_DIR:  dir_q  <= wdata;
          IDX_POL:  pol_q  <= wdata;
          IDX_MASK: mask_q <= wdata;
          default:  ;
        endcase
      end
    end
  end

  generate
    if (HAS_OWNER) begin : g_owner
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          own_q <= '1;
          aux_q <= '0;
        end else if (wen) begin
          if (idx == IDX_OWNER) own_q <= wdata;
          if (idx == IDX_AUX)   aux_q <= wdata;
        end
      end
    end else begin : g_plain
      assign own_q = '1;
      assign aux_q = '0;
    end
  endgenerate

  always_comb begin
    rdata = '0;
    case (idx)
      IDX_DOUT:   rdata = dout_q;
      IDX_DIR:    rdata = dir_q;
      IDX_POL:    rdata = pol_q;
      IDX_MASK:   rdata = mask_q;
      IDX_FLAG:   rdata = flag_q;
      IDX_PIN:    rdata = lvl;
      IDX_PINMIR: rdata = lvl;
      IDX_OWNER:  rdata = HAS_OWNER ? own_q : '0;
      IDX_AUX:    rdata = aux_q;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_dual_bank.sv
module gpio_dual_bank
  import gpio_dual_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_sel,
  input  logic             a_wr,
  input  logic [IDX_W-1:0] a_idx,
  input  logic [31:0]      a_wdata,
  output logic [31:0]      a_rdata,
  input  logic             b_sel,
  input  logic             b_wr,
  input  logic [IDX_W-1:0] b_idx,
  input  logic [31:0]      b_wdata,
  output logic [31:0]      b_rdata,
  input  logic [31:0]      pad_in,
  output logic [31:0]      pad_out,
  output logic [31:0]      pad_oe,
  output logic             a_irq,
  output logic             b_irq
);
  // Named internal events, visible to the bound checker
  logic [LINES-1:0] lvl_sync;
  logic [LINES-1:0] owner;
  logic [LINES-1:0] a_dout, a_dir, a_flag, a_mask, a_set, a_own;
  logic [LINES-1:0] b_dout, b_dir, b_flag, b_mask, b_set, b_own;

  gpio_sync2 #(.W(LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(lvl_sync)
  );

  assign owner = a_own & b_own;

  gpio_bank #(.W(LINES), .HAS_OWNER(1'b0)) u_bank_a (
    .clk(clk), .rst_n(rst_n), .sel(a_sel), .wr(a_wr), .idx(a_idx),
    .wdata(a_wdata), .rdata(a_rdata), .lvl(lvl_sync), .owned(owner),
    .dout_q(a_dout), .dir_q(a_dir), .flag_q(a_flag), .mask_q(a_mask),
    .set_v(a_set), .own_q(a_own), .irq(a_irq)
  );

  gpio_bank #(.W(LINES), .HAS_OWNER(1'b1)) u_bank_b (
    .clk(clk), .rst_n(rst_n), .sel(b_sel), .wr(b_wr), .idx(b_idx),
    .wdata(b_wdata), .rdata(b_rdata), .lvl(lvl_sync), .owned(~owner),
    .dout_q(b_dout), .dir_q(b_dir), .flag_q(b_flag), .mask_q(b_mask),
    .set_v(b_set), .own_q(b_own), .irq(b_irq)
  );

  assign pad_out = (owner & a_dout) | (~owner & b_dout);
  assign pad_oe  = (owner & a_dir)  | (~owner & b_dir);
endmodule

// File: rtl/gpio_dual_bank_chk.sv
module gpio_dual_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        a_sel,
  input logic        a_wr,
  input logic [3:0]  a_idx,
  input logic [31:0] a_wdata,
  input logic        b_sel,
  input logic        b_wr,
  input logic [3:0]  b_idx,
  input logic [31:0] b_wdata,
  input logic [31:0] owner,
  input logic [31:0] a_set,
  input logic [31:0] b_set,
  input logic [31:0] a_flag,
  input logic [31:0] b_flag,
  input logic [31:0] a_mask,
  input logic [31:0] b_mask,
  input logic [31:0] pad_oe,
  input logic [31:0] pad_out,
  input logic        a_irq,
  input logic        b_irq
);
  p_a_owned_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_set & ~owner) == 32'h0);
  p_b_owned_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (b_set & owner) == 32'h0);

  p_a_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (a_sel && a_wr && a_idx == 4'd4) |=> ((a_flag & $past(a_wdata & ~a_set)) == 32'h0));
  p_b_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (b_sel && b_wr && b_idx == 4'd4) |=> ((b_flag & $past(b_wdata & ~b_set)) == 32'h0));

  p_a_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_sel && a_wr && a_idx == 4'd4) |=> ((a_flag & $past(a_flag)) == $past(a_flag)));
  p_b_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(b_sel && b_wr && b_idx == 4'd4) |=> ((b_flag & $past(b_flag)) == $past(b_flag)));

  p_pads_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !((a_sel && a_wr) || (b_sel && b_wr)) |=> ($stable(pad_oe) && $stable(pad_out)));

  p_a_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (a_mask == 32'h0) |-> !a_irq);
  p_b_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (b_mask == 32'h0) |-> !b_irq);
endmodule

bind gpio_dual_bank gpio_dual_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_sel(a_sel), .a_wr(a_wr), .a_idx(a_idx), .a_wdata(a_wdata),
  .b_sel(b_sel), .b_wr(b_wr), .b_idx(b_idx), .b_wdata(b_wdata),
  .owner(owner), .a_set(a_set), .b_set(b_set),
  .a_flag(a_flag), .b_flag(b_flag), .a_mask(a_mask), .b_mask(b_mask),
  .pad_oe(pad_oe), .pad_out(pad_out), .a_irq(a_irq), .b_irq(b_irq)
);

// File: tb/gpio_dual_bank_bench.sv
`timescale 1ns/1ps
module gpio_dual_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_sel = 1'b0, a_wr = 1'b0, b_sel = 1'b0, b_wr = 1'b0;
  logic [3:0]  a_idx = '0, b_idx = '0;
  logic [31:0] a_wdata = '0, b_wdata = '0, a_rdata, b_rdata;
  logic [31:0] pad_in = '0, pad_out, pad_oe;
  logic        a_irq, b_irq;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  gpio_dual_bank u_gpio_dual_bank (
    .clk(clk), .rst_n(rst_n),
    .a_sel(a_sel), .a_wr(a_wr), .a_idx(a_idx), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_sel(b_sel), .b_wr(b_wr), .b_idx(b_idx), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .a_irq(a_irq), .b_irq(b_irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input bit bank_b, input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    if (bank_b) begin b_sel = 1; b_wr = 1; b_idx = idx; b_wdata = d; end
    else        begin a_sel = 1; a_wr = 1; a_idx = idx; a_wdata = d; end
    @(negedge clk);
    a_sel = 0; a_wr = 0; b_sel = 0; b_wr = 0;
  endtask

  task automatic rd_reg(input bit bank_b, input logic [3:0] idx, output logic [31:0] d);
    if (bank_b) begin b_sel = 1; b_idx = idx; end
    else        begin a_sel = 1; a_idx = idx; end
    #1;
    d = bank_b ? b_rdata : a_rdata;
    a_sel = 0; b_sel = 0;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd_reg(1, 4'd7, v);
    check("R1 owner", v, 32'hFFFF_FFFF);
    check("R1 pad_out", pad_out, 32'h0);
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 irqs", {30'h0, a_irq, b_irq}, 32'h0);
  endtask

  task automatic t_owner();
    logic [31:0] v;
    wr_reg(0, 4'd0, 32'h0000_00F0);
    wr_reg(0, 4'd1, 32'h0000_00FF);
    check("R2 pad_out from A", pad_out, 32'h0000_00F0);
    check("R2 pad_oe from A", pad_oe, 32'h0000_00FF);
    wr_reg(1, 4'd0, 32'h0F00_0000);
    wr_reg(1, 4'd1, 32'hFF00_0000);
    check("R3 B dir ignored", pad_oe, 32'h0000_00FF);
    check("R3 B out ignored", pad_out, 32'h0000_00F0);
    rd_reg(1, 4'd1, v);
    check("R3 B dir stored", v, 32'hFF00_0000);
    wr_reg(1, 4'd7, 32'h00FF_FFFF);
    check("R2 oe after handover", pad_oe, 32'hFF00_00FF);
    check("R2 out after handover", pad_out, 32'h0F00_00F0);
  endtask

  task automatic t_sync();
    logic [31:0] v;
    @(negedge clk);
    pad_in = 32'h1234_5678;
    edges(1);
    rd_reg(0, 4'd5, v);
    check("R4 not after one edge", v, 32'h0);
    edges(1);
    rd_reg(0, 4'd5, v); check("R4 A pin", v, 32'h1234_5678);
    rd_reg(0, 4'd6, v); check("R4 A mirror", v, 32'h1234_5678);
    rd_reg(1, 4'd5, v); check("R4 B pin", v, 32'h1234_5678);
    rd_reg(1, 4'd6, v); check("R4 B mirror", v, 32'h1234_5678);
  endtask

  task automatic t_level();
    logic [31:0] v;
    @(negedge clk);
    pad_in = 32'h0;
    edges(3);
    wr_reg(0, 4'd2, 32'h0000_0001);
    wr_reg(0, 4'd4, 32'hFFFF_FFFF);
    rd_reg(0, 4'd4, v);
    check("R5 R6 A flags active-low, owned", v, 32'h00FF_FFFE);
    wr_reg(1, 4'd4, 32'hFFFF_FFFF);
    rd_reg(1, 4'd4, v);
    check("R5 R6 B flags owned lines", v, 32'hFF00_0000);
    pad_in = 32'h0000_0001;
    edges(3);
    rd_reg(0, 4'd4, v);
    check("R5 active-high set, unmasked", v[0], 1'b1);
    check("R8 masked no irq", a_irq, 1'b0);
    wr_reg(0, 4'd3, 32'h0000_0001);
    check("R8 irq on mask", a_irq, 1'b1);
    pad_in = 32'h0;
    edges(3);
    rd_reg(0, 4'd4, v);
    check("R9 flag sticky", v[0], 1'b1);
    wr_reg(0, 4'd4, 32'h0);
    rd_reg(0, 4'd4, v);
    check("R7 zero write no effect", v[0], 1'b1);
    wr_reg(0, 4'd4, 32'h0000_0001);
    rd_reg(0, 4'd4, v);
    check("R7 one clears", v[0], 1'b0);
    check("R8 irq drops", a_irq, 1'b0);
    wr_reg(1, 4'd3, 32'h8000_0000);
    check("R8 B irq", b_irq, 1'b1);
    wr_reg(1, 4'd7, 32'h80FF_FFFF);
    wr_reg(1, 4'd4, 32'h8000_0000);
    rd_reg(1, 4'd4, v);
    check("R6 B loses line", v, 32'h7F00_0000);
    check("R8 B irq low", b_irq, 1'b0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr_reg(1, 4'd8, 32'hA5A5_A5A5);
    rd_reg(1, 4'd8, v);
    check("R11 aux stored", v, 32'hA5A5_A5A5);
    check("R11 pads unaffected", pad_oe, 32'h7F00_00FF);
    rd_reg(0, 4'd7, v); check("R10 A idx7 zero", v, 32'h0);
    rd_reg(0, 4'd8, v); check("R10 A idx8 zero", v, 32'h0);
    rd_reg(1, 4'd15, v); check("R10 unmapped zero", v, 32'h0);
    rd_reg(0, 4'd2, v); check("R10 A polarity", v, 32'h0000_0001);
  endtask

  initial begin
    #10_000_000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    edges(2);
    rst_n = 1'b1;
    t_reset();
    t_owner();
    t_sync();
    t_level();
    t_map();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule